// File: doc/BRIEF.md
# Single-Wire Bus Presence Responder

This block sits on the slave side of an open-drain single-wire bus. It watches the synchronized line level and measures how long each low period lasts, counting one-microsecond ticks from a shared timebase. A low that is long enough to be a bus reset is answered once the line rises again. After a short fixed wait, the block pulls the line low for a fixed time. That pulse tells the master that a slave is present.

Three kinds of low period are handled differently. A low shorter than the reset threshold is an ordinary time slot. The block leaves it to the data-slot logic and does not respond. A low in the reset window produces the presence answer. A low that reaches the power-on limit raises a one-cycle power-on-reset request, and its release does not produce a presence pulse. While the block is waiting to answer or is driving its answer, it ignores the line. It starts measuring again only after it has released the line and has seen the line high. When the presence pulse ends, a one-cycle strobe tells the slave's upper logic that a bus reset has been handled.

Top module: `sw_presence_responder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `drive_low`, `reset_seen` and `por_req` are all 0.
- R2: A low of fewer than RESET_MIN_US ticks (default 480) causes no presence pulse and no `reset_seen` strobe. Such a low is left to the time-slot logic.
- R3: A low of at least RESET_MIN_US ticks and fewer than POR_LIMIT_US ticks makes `drive_low` rise PRES_DELAY_US ticks (default 30) after the first clock edge that samples the line high.
- R4: The presence pulse holds `drive_low` at 1 for exactly PRES_WIDTH_US ticks (default 120) and then releases it.
- R5: `reset_seen` is 1 for exactly one cycle, beginning at the clock edge where `drive_low` falls at the end of a presence pulse.
- R6: When a low reaches POR_LIMIT_US ticks (default 5000), `por_req` is 1 for one cycle, after the edge that counts the final tick. Releasing that low gives no presence pulse.
- R7: A low that begins while a presence answer is pending or being driven is not measured. Its release gives no new presence pulse. Measuring restarts once the block has released the line and has sampled it high.
- R8: `drive_low` is never 1 except during a presence pulse. The block starts no other signalling on the bus.
- R9: All durations advance only in cycles where `tick_us` is 1. A low held with no ticks has zero length and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| line_in | input | 1 | Synchronized bus level (1 = released/high) |
| drive_low | output | 1 | Open-drain enable: 1 pulls the bus low |
| reset_seen | output | 1 | One-cycle strobe when a presence answer completes |
| por_req | output | 1 | One-cycle power-on-reset request on an overlong low |

## Verification
The bench sweeps every low length from one tick up past the power-on limit. This covers both edges of the reset window. A design whose comparison was off by one would answer a low one tick too short, would miss a low of exactly the threshold, or would answer a low that had already raised the power-on request. In every sweep step the bench checks the start offset, the width and the strobe position of the presence pulse. A sequencer with an extra or a missing wait state would shift the pulse or change its width by one cycle. One test holds the bus low from the master side, starting in the middle of an answer. A responder that measured its own pulse, or the master's overlapping low, would answer a second time when the line is released. One test holds the line low with the tick stopped. A timer that counted clocks instead of ticks would respond to it.

// File: rtl/swp_pkg.sv
// Package: shared types for the single-wire presence responder.
// Assumes: nothing beyond IEEE 1800-2017.
package swp_pkg;

    // Phases of the presence answer sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_DRIVE = 2'd2
    } pres_phase_t;

endpackage

// File: rtl/swp_low_timer.sv
// Module: swp_low_timer
// Measures the current low period of the bus in microsecond ticks while
// measurement is armed. Reports whether the count lies inside the reset
// window, and pulses por_pulse once when the count reaches the power-on limit.
// Assumes: line_in is already synchronized; tick_us is a one-cycle strobe;
// RESET_MIN_US < POR_LIMIT_US.
module swp_low_timer #(
    parameter int RESET_MIN_US = 480,
    parameter int POR_LIMIT_US = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic line_in,
    input  logic armed,
    output logic in_window,
    output logic por_pulse
);

    localparam int CNT_W = $clog2(POR_LIMIT_US + 1);
    localparam logic [CNT_W-1:0] RMIN_C = CNT_W'(RESET_MIN_US);
    localparam logic [CNT_W-1:0] POR_C  = CNT_W'(POR_LIMIT_US);
    localparam logic [CNT_W-1:0] POR_PRE_C = CNT_W'(POR_LIMIT_US - 1);

    logic [CNT_W-1:0] low_cnt;

    // Count low ticks, saturating at the power-on limit; clear on high or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!armed || line_in) begin
            low_cnt <= '0;
        end else if (tick_us && (low_cnt < POR_C)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Raise the power-on request for the cycle after the final tick of the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_pulse <= 1'b0;
        end else begin
            por_pulse <= armed && !line_in && tick_us && (low_cnt == POR_PRE_C);
        end
    end

    // A finished low qualifies as a reset inside [RESET_MIN, POR_LIMIT).
    always_comb begin
        in_window = (low_cnt >= RMIN_C) && (low_cnt < POR_C);
    end

endmodule

// File: rtl/swp_presence_seq.sv
// Module: swp_presence_seq
// On start, waits DELAY_US ticks and then drives the line low for WIDTH_US
// ticks. Pulses done in the cycle in which the drive is released.
// Assumes: DELAY_US >= 1 and WIDTH_US >= 1; start is ignored while busy.
module swp_presence_seq
    import swp_pkg::*;
#(
    parameter int DELAY_US = 30,
    parameter int WIDTH_US = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic start,
    output logic busy,
    output logic drive,
    output logic done
);

    localparam int MAX_US = (DELAY_US > WIDTH_US) ? DELAY_US : WIDTH_US;
    localparam int SEQ_W  = $clog2(MAX_US + 1);
    localparam logic [SEQ_W-1:0] DLY_LAST = SEQ_W'(DELAY_US - 1);
    localparam logic [SEQ_W-1:0] WID_LAST = SEQ_W'(WIDTH_US - 1);

    pres_phase_t      phase;
    logic [SEQ_W-1:0] cnt;

    // Step through idle, wait and drive phases on microsecond ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end
                end
                PH_WAIT: begin
                    if (tick_us) begin
                        if (cnt == DLY_LAST) begin
                            phase <= PH_DRIVE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DRIVE: begin
                    if (tick_us) begin
                        if (cnt == WID_LAST) begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Decode phase into the busy flag and the open-drain enable.
    always_comb begin
        busy  = (phase != PH_IDLE);
        drive = (phase == PH_DRIVE);
    end

endmodule

// File: rtl/sw_presence_responder.sv
// Module: sw_presence_responder (top)
// Slave-side reset detector and presence answerer for an open-drain
// single-wire bus. Measures each low period. Answers a reset-length low with
// a delayed presence pulse, flags an overlong low as a power-on-reset request,
// and leaves short lows to the time-slot logic.
// Assumes: line_in is synchronized to clk and reflects the wired-AND bus,
// including this block's own drive; tick_us strobes once per microsecond.
module sw_presence_responder #(
    parameter int RESET_MIN_US  = 480,
    parameter int POR_LIMIT_US  = 5000,
    parameter int PRES_DELAY_US = 30,
    parameter int PRES_WIDTH_US = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic line_in,
    output logic drive_low,
    output logic reset_seen,
    output logic por_req
);

    logic armed;
    logic in_window;
    logic seq_busy;
    logic start;

    swp_low_timer #(
        .RESET_MIN_US (RESET_MIN_US),
        .POR_LIMIT_US (POR_LIMIT_US)
    ) low_timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .line_in   (line_in),
        .armed     (armed),
        .in_window (in_window),
        .por_pulse (por_req)
    );

    swp_presence_seq #(
        .DELAY_US (PRES_DELAY_US),
        .WIDTH_US (PRES_WIDTH_US)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_us (tick_us),
        .start   (start),
        .busy    (seq_busy),
        .drive   (drive_low),
        .done    (reset_seen)
    );

    // A reset ends at the first high sample after a qualifying low.
    always_comb begin
        start = armed && line_in && in_window && !seq_busy;
    end

    // Disarm while answering; rearm only once idle and the line is seen high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (start) begin
            armed <= 1'b0;
        end else if (!armed && !seq_busy && line_in) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/swp_presence_checker.sv
// Module: swp_presence_checker
// Temporal properties of the responder's outputs, bound to the top module.
// Assumes: the same PRES_WIDTH_US value as the bound instance.
module swp_presence_checker #(
    parameter int PRES_WIDTH_US = 120
) (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic drive_low,
    input logic reset_seen,
    input logic por_req
);

    localparam int DT_W = $clog2(PRES_WIDTH_US + 2);

    logic [DT_W-1:0] drive_ticks;

    // Count ticks spent driving the line in the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive_low) begin
            drive_ticks <= '0;
        end else if (tick_us) begin
            drive_ticks <= drive_ticks + 1'b1;
        end
    end

    a_r4_drive_ticks_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        drive_ticks <= DT_W'(PRES_WIDTH_US));

    a_r5_seen_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> reset_seen);

    a_r5_seen_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !reset_seen);

    a_r5_seen_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> $past(drive_low));

    a_r6_por_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> !por_req);

    a_r7_no_por_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> !drive_low);

endmodule

bind sw_presence_responder swp_presence_checker #(
    .PRES_WIDTH_US (PRES_WIDTH_US)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .drive_low  (drive_low),
    .reset_seen (reset_seen),
    .por_req    (por_req)
);

// File: tb/sw_presence_responder_tb_top.sv
// Bench: sweeps low lengths over a small configuration and compares the
// presence waveform and power-on request against arithmetic expectations.
module sw_presence_responder_tb_top;

    localparam int RMIN = 48;
    localparam int PORL = 200;
    localparam int DLY  = 3;
    localparam int WID  = 12;
    localparam int WATCH = DLY + WID + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b1;
    logic master = 1'b1;
    logic line_in;
    logic drive_low;
    logic reset_seen;
    logic por_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Wired-AND bus: master or slave may pull low.
    assign line_in = master & ~drive_low;

    sw_presence_responder #(
        .RESET_MIN_US  (RMIN),
        .POR_LIMIT_US  (PORL),
        .PRES_DELAY_US (DLY),
        .PRES_WIDTH_US (WID)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .line_in    (line_in),
        .drive_low  (drive_low),
        .reset_seen (reset_seen),
        .por_req    (por_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Hold the master low for len cycles, release, and record the response.
    task automatic run_low(input int len, output int por_at, output int por_n,
                           output int first, output int dcount, output int seen_t,
                           output int seen_n, output int early);
        por_at = 0; por_n = 0; first = 0; dcount = 0; seen_t = 0; seen_n = 0; early = 0;
        @(negedge clk);
        master = 1'b0;
        for (int k = 1; k <= len; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (por_req) begin por_n++; por_at = k; end
            if (drive_low) early++;
        end
        master = 1'b1;
        for (int t = 1; t <= WATCH; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (drive_low) begin
                dcount++;
                if (first == 0) first = t;
            end
            if (reset_seen) begin seen_n++; seen_t = t; end
            if (por_req) por_n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int por_at, por_n, first, dcount, seen_t, seen_n, early;
        bit pres;
        string rq;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "drive_low in reset", int'(drive_low), 0);
        chk("R1", "reset_seen in reset", int'(reset_seen), 0);
        chk("R1", "por_req in reset", int'(por_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after release", int'({drive_low, reset_seen, por_req}), 0);
        repeat (3) @(negedge clk);

        // R2, R3, R4, R5, R6, R8: sweep every low length across both boundaries
        for (int len = 1; len <= PORL + 20; len++) begin
            run_low(len, por_at, por_n, first, dcount, seen_t, seen_n, early);
            pres = (len >= RMIN) && (len < PORL);
            rq = pres ? "R3" : ((len >= PORL) ? "R6" : "R2");
            chk(rq, $sformatf("first drive sample, len %0d", len), first, pres ? DLY + 1 : 0);
            chk("R4", $sformatf("drive width, len %0d", len), dcount, pres ? WID : 0);
            chk("R5", $sformatf("strobe position, len %0d", len), seen_t, pres ? DLY + WID + 1 : 0);
            chk("R5", $sformatf("strobe count, len %0d", len), seen_n, pres ? 1 : 0);
            chk("R6", $sformatf("por position, len %0d", len), por_at, (len >= PORL) ? PORL : 0);
            chk("R6", $sformatf("por count, len %0d", len), por_n, (len >= PORL) ? 1 : 0);
            chk("R8", $sformatf("drive during master low, len %0d", len), early, 0);
        end

        // R7: master pulls low mid-answer and holds past the answer's end
        begin
            int seen_cnt = 0;
            int drive_after = 0;
            int por_cnt = 0;
            @(negedge clk);
            master = 1'b0;
            repeat (60) @(negedge clk);
            master = 1'b1;
            repeat (DLY + 3) @(negedge clk);
            chk("R7", "answer in progress before overlap", int'(drive_low), 1);
            master = 1'b0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (reset_seen) seen_cnt++;
                if (por_req) por_cnt++;
            end
            master = 1'b1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (drive_low) drive_after++;
                if (reset_seen) seen_cnt++;
                if (por_req) por_cnt++;
            end
            chk("R7", "strobes across overlap", seen_cnt, 1);
            chk("R7", "drive after overlapping low", drive_after, 0);
            chk("R7", "por during overlapping low", por_cnt, 0);
            run_low(60, por_at, por_n, first, dcount, seen_t, seen_n, early);
            chk("R7", "fresh reset after overlap: first", first, DLY + 1);
            chk("R7", "fresh reset after overlap: width", dcount, WID);
        end

        // R9: a low with the tick stopped has no length
        @(negedge clk);
        tick_us = 1'b0;
        run_low(100, por_at, por_n, first, dcount, seen_t, seen_n, early);
        chk("R9", "drive with no ticks", dcount, 0);
        chk("R9", "strobe with no ticks", seen_n, 0);
        tick_us = 1'b1;
        repeat (3) @(negedge clk);
        run_low(RMIN, por_at, por_n, first, dcount, seen_t, seen_n, early);
        chk("R9", "ticks restored: first", first, DLY + 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule